// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds one 32-bit register that is copied across a grid of hardware units, arranged as groups that each hold several instances. Every copy answers at one shared data address on a simple register bus. A second address holds a steering selector with a group field, an instance field and a broadcast bit. The selector decides which copy a data access reaches.

A data write with the broadcast bit set updates every copy that exists. With the bit clear, it updates only the copy named by the selector. A data read always returns the single named copy, whatever the broadcast bit says. Two per-unit input masks, one for "present" and one for "powered", mark which copies are live. An access steered at a copy that is not live is terminated without any error: a read returns zero and a write is dropped. Copies that are not live keep their stored value. Software normally leaves the selector in broadcast mode and sets it back to broadcast after each single-copy write.

Top module: `steer_rep_bank`

## Requirements
- R1: After reset, a read of the selector returns 0x8000_0000 (broadcast=1, group=0, instance=0), and every copy holds zero.
- R2: The selector sits at bus address 0, with the instance in bits [3:0], the group in bits [11:8] and the broadcast bit in bit 31. A write stores these three fields, and a read returns them in place with every other bit read as zero.
- R3: A write to the data address (bus address 4) with broadcast=1 stores the write data in every live copy.
- R4: A broadcast write leaves every copy that is not live (present=0 or powered=0) at its old value.
- R5: A data write with broadcast=0 stores the data only in the copy at index group*NUM_INSTS+instance, and only if that copy is live. All other copies are unchanged.
- R6: A data write with broadcast=0 that is steered at a copy that is not live is dropped. When the copy later becomes live again, it still holds its earlier value.
- R7: A data read returns the copy named by the selector's group and instance, with broadcast either 1 or 0.
- R8: A data read steered at a copy that is not live returns zero.
- R9: A group field at or above NUM_GROUPS, or an instance field at or above NUM_INSTS, counts as a terminated target: reads return zero and writes change no copy.
- R10: Read data appears on bus_rdata one clock after the read is accepted, and it holds until the next read.
- R11: A read of any address other than 0 or 4 returns zero, and a write to such an address changes no copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| unit_present | input | NUM_GROUPS*NUM_INSTS | Per-copy present flags, index group*NUM_INSTS+instance |
| unit_powered | input | NUM_GROUPS*NUM_INSTS | Per-copy powered flags, same indexing |

## Verification
The bench drives every access on a falling edge and holds it for one full cycle. Selector and copy updates land on the rising edge inside that cycle. Read data lands on bus_rdata on that same edge and is sampled at the next falling edge, which gives exactly one cycle of read latency. Copy contents are observed only through steered reads, each issued as a separate access after its selector write. The sweeps cover each of the 16 copies in turn as a terminated target, broadcast writes under mixed masks, and steering fields beyond the grid. The expected value of every read comes from a model array in the bench, updated by the live and target rules stated above.

// File: rtl/steer_rep_pkg.sv
package steer_rep_pkg;

   localparam int SEL_INST_LSB = 0;
   localparam int SEL_GRP_LSB  = 8;
   localparam int SEL_MC_BIT   = 31;
   localparam int SEL_FLD_W    = 4;
   localparam int SEL_WORD_W   = 32;

   typedef struct packed {
      logic                 mc;
      logic [SEL_FLD_W-1:0] grp;
      logic [SEL_FLD_W-1:0] inst;
   } steer_sel_t;

   localparam steer_sel_t SEL_RESET = '{mc: 1'b1, grp: '0, inst: '0};

   function automatic steer_sel_t sel_unpack(input logic [SEL_WORD_W-1:0] w);
      steer_sel_t s;
      s.mc   = w[SEL_MC_BIT];
      s.grp  = w[SEL_GRP_LSB +: SEL_FLD_W];
      s.inst = w[SEL_INST_LSB +: SEL_FLD_W];
      return s;
   endfunction

   function automatic logic [SEL_WORD_W-1:0] sel_pack(input steer_sel_t s);
      logic [SEL_WORD_W-1:0] w;
      w = '0;
      w[SEL_MC_BIT]                 = s.mc;
      w[SEL_GRP_LSB +: SEL_FLD_W]   = s.grp;
      w[SEL_INST_LSB +: SEL_FLD_W]  = s.inst;
      return w;
   endfunction

endpackage

// File: rtl/steer_sel_reg.sv
module steer_sel_reg
   import steer_rep_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [SEL_WORD_W-1:0] wr_word,
   output steer_sel_t            sel_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= SEL_RESET;
      else if (wr_en)
         sel_q <= sel_unpack(wr_word);
   end

endmodule

// File: rtl/steer_target_dec.sv
module steer_target_dec
   import steer_rep_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int NUM_INSTS  = 4,
   localparam int LANES     = NUM_GROUPS * NUM_INSTS
) (
   input  steer_sel_t       sel,
   input  logic [LANES-1:0] present,
   input  logic [LANES-1:0] powered,
   output logic [LANES-1:0] hit_vec,
   output logic [LANES-1:0] live_vec
);

   assign live_vec = present & powered;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      for (genvar i = 0; i < NUM_INSTS; i++) begin : g_inst
         assign hit_vec[g*NUM_INSTS + i] =
            (sel.grp == SEL_FLD_W'(g)) && (sel.inst == SEL_FLD_W'(i));
      end
   end

endmodule

// File: rtl/steer_lane_bank.sv
module steer_lane_bank #(
   parameter int LANES  = 16,
   parameter int DATA_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_stb,
   input  logic                    mc,
   input  logic [LANES-1:0]        hit_vec,
   input  logic [LANES-1:0]        live_vec,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [LANES*DATA_W-1:0] lane_flat
);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic              we;
      logic [DATA_W-1:0] val_q;

      assign we = wr_stb && live_vec[k] && (mc || hit_vec[k]);

      always_ff @(posedge clk) begin
         if (!rst_n)
            val_q <= '0;
         else if (we)
            val_q <= wr_data;
      end

      assign lane_flat[k*DATA_W +: DATA_W] = val_q;
   end

endmodule

// File: rtl/steer_read_mux.sv
module steer_read_mux #(
   parameter int LANES  = 16,
   parameter int DATA_W = 32
) (
   input  logic [LANES*DATA_W-1:0] lane_flat,
   input  logic [LANES-1:0]        hit_vec,
   input  logic [LANES-1:0]        live_vec,
   output logic [DATA_W-1:0]       rd_word
);

   always_comb begin
      rd_word = '0;
      for (int k = 0; k < LANES; k++) begin
         if (hit_vec[k] && live_vec[k])
            rd_word = rd_word | lane_flat[k*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/steer_rep_bank.sv
module steer_rep_bank
   import steer_rep_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int NUM_INSTS  = 4,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int SEL_ADDR   = 0,
   parameter int DAT_ADDR   = 4,
   localparam int LANES     = NUM_GROUPS * NUM_INSTS
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_valid,
   input  logic                    bus_write,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   input  logic [LANES-1:0]        unit_present,
   input  logic [LANES-1:0]        unit_powered
);

   if (NUM_GROUPS < 1 || NUM_GROUPS > (1 << SEL_FLD_W)) begin : g_bad_groups
      $error("NUM_GROUPS must fit the selector group field");
   end
   if (NUM_INSTS < 1 || NUM_INSTS > (1 << SEL_FLD_W)) begin : g_bad_insts
      $error("NUM_INSTS must fit the selector instance field");
   end
   if (DATA_W != SEL_WORD_W) begin : g_bad_width
      $error("DATA_W must equal the selector word width");
   end
   if (SEL_ADDR == DAT_ADDR || SEL_ADDR >= (1 << ADDR_W) || DAT_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("selector and data addresses must be distinct and fit ADDR_W");
   end

   logic hit_sel, hit_dat, rd_acc;
   assign hit_sel = bus_valid && (bus_addr == ADDR_W'(SEL_ADDR));
   assign hit_dat = bus_valid && (bus_addr == ADDR_W'(DAT_ADDR));
   assign rd_acc  = bus_valid && !bus_write;

   steer_sel_t              sel_q;
   logic [LANES-1:0]        hit_vec, live_vec;
   logic [LANES*DATA_W-1:0] lane_flat;
   logic [DATA_W-1:0]       lane_rd;
   logic [DATA_W-1:0]       rd_next;
   logic [DATA_W-1:0]       rdata_q;

   steer_sel_reg u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (hit_sel && bus_write),
      .wr_word (bus_wdata),
      .sel_q   (sel_q)
   );

   steer_target_dec #(
      .NUM_GROUPS (NUM_GROUPS),
      .NUM_INSTS  (NUM_INSTS)
   ) u_dec (
      .sel      (sel_q),
      .present  (unit_present),
      .powered  (unit_powered),
      .hit_vec  (hit_vec),
      .live_vec (live_vec)
   );

   steer_lane_bank #(
      .LANES  (LANES),
      .DATA_W (DATA_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (hit_dat && bus_write),
      .mc        (sel_q.mc),
      .hit_vec   (hit_vec),
      .live_vec  (live_vec),
      .wr_data   (bus_wdata),
      .lane_flat (lane_flat)
   );

   steer_read_mux #(
      .LANES  (LANES),
      .DATA_W (DATA_W)
   ) u_rmux (
      .lane_flat (lane_flat),
      .hit_vec   (hit_vec),
      .live_vec  (live_vec),
      .rd_word   (lane_rd)
   );

   always_comb begin
      if (hit_sel)
         rd_next = DATA_W'(sel_pack(sel_q));
      else if (hit_dat)
         rd_next = lane_rd;
      else
         rd_next = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (rd_acc)
         rdata_q <= rd_next;
   end

   assign bus_rdata = rdata_q;

endmodule

// File: rtl/steer_rep_bank_chk.sv
module steer_rep_bank_chk
   import steer_rep_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int NUM_INSTS  = 4,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int SEL_ADDR   = 0,
   parameter int DAT_ADDR   = 4,
   localparam int LANES     = NUM_GROUPS * NUM_INSTS
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bus_valid,
   input logic                    bus_write,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [DATA_W-1:0]       bus_wdata,
   input logic [DATA_W-1:0]       bus_rdata,
   input logic [LANES-1:0]        unit_present,
   input logic [LANES-1:0]        unit_powered,
   input steer_sel_t              sel_q,
   input logic [LANES*DATA_W-1:0] lane_flat
);

   logic [LANES-1:0]        tgt_k;
   logic [LANES*DATA_W-1:0] allow_bits;
   logic                    tgt_live;
   logic                    dat_acc, sel_wr, uni_wr;

   for (genvar k = 0; k < LANES; k++) begin : g_k
      assign tgt_k[k] = (sel_q.grp  == SEL_FLD_W'(k / NUM_INSTS)) &&
                        (sel_q.inst == SEL_FLD_W'(k % NUM_INSTS));
      assign allow_bits[k*DATA_W +: DATA_W] = {DATA_W{tgt_k[k]}};
   end

   assign tgt_live = |(tgt_k & unit_present & unit_powered);
   assign dat_acc  = bus_valid && (bus_addr == ADDR_W'(DAT_ADDR));
   assign sel_wr   = bus_valid && bus_write && (bus_addr == ADDR_W'(SEL_ADDR));
   assign uni_wr   = dat_acc && bus_write && !sel_q.mc;

   p_sel_mc_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> (sel_q.mc == $past(bus_wdata[SEL_MC_BIT])));

   p_unicast_scope_r5: assert property (@(posedge clk) disable iff (!rst_n)
      uni_wr |=> (((lane_flat ^ $past(lane_flat)) & ~$past(allow_bits)) == '0));

   p_term_write_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (uni_wr && !tgt_live) |=> $stable(lane_flat));

   p_term_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_acc && !bus_write && !tgt_live) |=> (bus_rdata == '0));

   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && !bus_write) |=> $stable(bus_rdata));

   p_lanes_untouched_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(dat_acc && bus_write) |=> $stable(lane_flat));

endmodule

bind steer_rep_bank steer_rep_bank_chk #(
   .NUM_GROUPS (NUM_GROUPS),
   .NUM_INSTS  (NUM_INSTS),
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .SEL_ADDR   (SEL_ADDR),
   .DAT_ADDR   (DAT_ADDR)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_valid    (bus_valid),
   .bus_write    (bus_write),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .unit_present (unit_present),
   .unit_powered (unit_powered),
   .sel_q        (sel_q),
   .lane_flat    (lane_flat)
);

// File: tb/steer_rep_bank_tb_top.sv
`timescale 1ns/1ps
module steer_rep_bank_tb_top;

   localparam int NG = 4;
   localparam int NI = 4;
   localparam int NL = NG * NI;
   localparam logic [3:0] A_SEL = 4'd0;
   localparam logic [3:0] A_DAT = 4'd4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic          bus_write = 1'b0;
   logic [3:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NL-1:0] pres = '1;
   logic [NL-1:0] pow = '1;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [31:0] model [NL];
   int cur_g = 0, cur_i = 0;
   bit cur_mc = 1'b1;

   always #2.5 clk = ~clk;

   steer_rep_bank dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_valid    (bus_valid),
      .bus_write    (bus_write),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .unit_present (pres),
      .unit_powered (pow)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata;
   endtask

   function automatic bit is_live(input int k);
      return pres[k] && pow[k];
   endfunction

   function automatic bit in_grid(input int g, input int i);
      return (g < NG) && (i < NI);
   endfunction

   task automatic set_sel(input int g, input int i, input bit mc);
      bus_wr(A_SEL, {mc, 19'd0, 4'(g), 4'd0, 4'(i)});
      cur_g = g; cur_i = i; cur_mc = mc;
   endtask

   task automatic data_wr(input logic [31:0] d);
      bus_wr(A_DAT, d);
      for (int k = 0; k < NL; k++) begin
         if (is_live(k) && (cur_mc || (in_grid(cur_g, cur_i) && k == cur_g*NI + cur_i)))
            model[k] = d;
      end
   endtask

   task automatic read_chk(input string tag, input int g, input int i, input bit mc);
      logic [31:0] v, e;
      set_sel(g, i, mc);
      bus_rd(A_DAT, v);
      e = (in_grid(g, i) && is_live(g*NI + i)) ? model[g*NI + i] : 32'd0;
      chk(tag, v, e);
   endtask

   task automatic read_all(input string tag, input bit mc);
      for (int k = 0; k < NL; k++) read_chk(tag, k / NI, k % NI, mc);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v, held;
      for (int k = 0; k < NL; k++) model[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of selector and copies
      bus_rd(A_SEL, v);
      chk("R1 selector reset", v, 32'h8000_0000);
      read_all("R1 copy reset", 1'b1);

      // R3 / R7: broadcast write, read each copy with both mode values
      set_sel(0, 0, 1'b1);
      data_wr(32'hA5A5_0000);
      read_all("R3 broadcast all live", 1'b1);
      read_all("R7 read with broadcast=0", 1'b0);

      // R5: single-copy writes, each copy a distinct value
      for (int k = 0; k < NL; k++) begin
         set_sel(k / NI, k % NI, 1'b0);
         data_wr(32'h1000_0000 + k * 32'h111);
         set_sel(0, 0, 1'b1);
      end
      read_all("R5 single-copy values", 1'b0);
      read_all("R7 read with broadcast=1", 1'b1);

      // R4 / R8: broadcast under mixed masks
      pres = 16'hF0F3; pow = 16'hBFFF;
      set_sel(0, 0, 1'b1);
      data_wr(32'hDEAD_0001);
      read_all("R8 terminated read zero", 1'b1);
      pres = '1; pow = '1;
      read_all("R4 terminated copy kept", 1'b1);

      // R6 / R8: each copy terminated alone in turn
      for (int k = 0; k < NL; k++) begin
         if (k % 2 == 0) pres = ~(16'd1 << k); else pow = ~(16'd1 << k);
         set_sel(k / NI, k % NI, 1'b0);
         data_wr(32'hBAD0_0000 + k);
         read_chk("R8 gated copy reads zero", k / NI, k % NI, 1'b0);
         pres = '1; pow = '1;
         read_chk("R6 dropped write keeps value", k / NI, k % NI, 1'b1);
      end

      // R9: steering fields outside the grid
      set_sel(5, 0, 1'b0);
      data_wr(32'h5555_5555);
      read_chk("R9 group out of range read", 5, 0, 1'b0);
      set_sel(1, 9, 1'b0);
      data_wr(32'h6666_6666);
      read_chk("R9 instance out of range read", 1, 9, 1'b1);
      read_all("R9 no copy changed", 1'b1);

      // R2: selector field placement
      bus_wr(A_SEL, 32'h1234_5F3A);
      bus_rd(A_SEL, v);
      chk("R2 selector fields mc=0", v, 32'h0000_0F0A);
      bus_wr(A_SEL, 32'hFFFF_FFFF);
      bus_rd(A_SEL, v);
      chk("R2 selector fields all ones", v, 32'h8000_0F0F);
      bus_wr(A_SEL, 32'h8000_0203);
      bus_rd(A_SEL, v);
      chk("R2 selector group 2 inst 3", v, 32'h8000_0203);
      cur_g = 2; cur_i = 3; cur_mc = 1'b1;

      // R10: one-cycle latency and hold
      bus_rd(A_DAT, held);
      chk("R10 read after one cycle", held, model[2*NI + 3]);
      repeat (4) @(negedge clk);
      chk("R10 rdata held while idle", bus_rdata, held);
      bus_wr(A_SEL, 32'h8000_0000);
      cur_g = 0; cur_i = 0;
      @(negedge clk);
      chk("R10 rdata held across write", bus_rdata, held);

      // R11: unmapped address
      bus_wr(4'd8, 32'hFFFF_FFFF);
      bus_rd(4'd8, v);
      chk("R11 unmapped read zero", v, 32'd0);
      bus_wr(4'd12, 32'h0F0F_0F0F);
      read_all("R11 unmapped write ignored", 1'b1);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule